// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator with Wrap Timer

This block gathers interrupt events from three kinds of source into one active-high interrupt request line. The first kind is a set of host network-controller events, such as FIFO thresholds, overflows, a receive watchdog expiry and receive or transmit errors. The second kind is a power-management group with its own status and enable registers. The third is a 16-bit down-counting timer that raises an event each time it wraps from zero to FFFFh. Each source latches a sticky status bit. Software clears a status bit by writing 1 to it. A per-source enable decides whether a pending bit reaches the request line, and a master output enable sits above all of the per-source enables.

The power-management group is collected in two levels. Three sub-level events are the energy-detect indications of two ports and a wake-up detection (wake frame or magic packet). Each of them latches into a sub-level status register and has a sub-level enable. The OR of the enabled pending sub-level bits appears as one read-only summary bit in the top-level status register. The top-level enable then gates that summary bit. Software reaches every register through a simple synchronous word-addressed port. Read data is registered.

Register map (word addresses): 0 top status, 1 top enable, 2 configuration, 3 power sub-status, 4 power sub-enable, 5 timer reload, 6 timer count (read-only).

Top module: `irq_agg_top`

## Requirements
- R1: After reset, all status and enable registers and the configuration register read 0, the timer count and reload read FFFFh, and `irq` is low.
- R2: A pulse on `mac_evt[i]` sets top status bit i (address 0, bits N_MAC-1:0) whether or not enable bit i is set.
- R3: Writing a 1 to a top or sub-level status bit clears that bit. Writing a 0 leaves the bit unchanged.
- R4: When an event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R5: `pm_evt[0]` (port 1 energy), `pm_evt[1]` (port 2 energy) and `pm_evt[2]` (wake detect) latch into sub-status bits 15, 14 and 9 (address 3). The sub-enables sit at the same bit positions in address 4.
- R6: Top status bit 17 reads 1 exactly when some sub-status bit is set together with its sub-enable. Writes to top status bit 17 have no effect.
- R7: The timer count (address 6) decrements once per clock while configuration bit 29 is set, and holds its value while that bit is clear.
- R8: When a running count steps from 0 it becomes FFFFh and sets top status bit 19.
- R9: Writing the reload register (address 5) loads that value into the count at once, even while the timer runs.
- R10: `irq` is the registered OR of every pending top status bit whose enable (address 1, same bit position) is set, ANDed with configuration bit 8. Bit 19 counts only while the timer runs. `irq` follows a register change one clock later.
- R11: `reg_rdata` presents the register chosen by `reg_addr` one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| mac_evt | input | N_MAC | Host network-controller event pulses |
| pm_evt | input | 3 | Power events: port 1 energy, port 2 energy, wake detect |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench drives an event and a write-1 clear into the same bit in the same cycle. A design that let the clear win would lose that event and read 0. It tries to clear the read-only power summary bit through the top status register, and expects the summary to persist until the enabled sub-level bit is cleared. A design that made the summary sticky, or that counted disabled sub-bits, would read back the wrong value. It times the timer wrap to the exact edge, so an off-by-one in the wrap or the reload shows up as a wrong count. It also checks that `irq` rises only one clock after the last enable lands, and that a pending timer event stops driving `irq` once the timer is stopped.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 32;
  localparam int TMR_W  = 16;

  localparam logic [REG_AW-1:0] A_STAT   = 3'd0;
  localparam logic [REG_AW-1:0] A_EN     = 3'd1;
  localparam logic [REG_AW-1:0] A_CFG    = 3'd2;
  localparam logic [REG_AW-1:0] A_PMSTAT = 3'd3;
  localparam logic [REG_AW-1:0] A_PMEN   = 3'd4;
  localparam logic [REG_AW-1:0] A_RELOAD = 3'd5;
  localparam logic [REG_AW-1:0] A_COUNT  = 3'd6;

  localparam int B_PM_SUM  = 17;
  localparam int B_TIMER   = 19;
  localparam int B_IRQ_EN  = 8;
  localparam int B_TMR_RUN = 29;

  localparam int N_PM = 3;
  localparam int PM_POS [N_PM] = '{15, 14, 9};
endpackage

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  always_ff @(posedge clk) begin
    if (rst) stat_o <= '0;
    else     stat_o <= (stat_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/irq_gp_timer.sv
module irq_gp_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  always_ff @(posedge clk) begin
    if (rst)        count_o <= ALL_ONES;
    else if (load_i) count_o <= load_val_i;
    else if (run_i)  count_o <= count_o - 1'b1;
  end

  assign wrap_o = run_i & ~load_i & (count_o == '0);
endmodule

// File: rtl/irq_out_gate.sv
module irq_out_gate #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pend_i,
  input  logic [W-1:0] en_i,
  input  logic         master_i,
  output logic         irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= master_i & (|(pend_i & en_i));
  end
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int N_MAC = 13
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [REG_DW-1:0]   reg_wdata,
  output logic [REG_DW-1:0]   reg_rdata,
  input  logic [N_MAC-1:0]    mac_evt,
  input  logic [N_PM-1:0]     pm_evt,
  output logic                irq
);
  localparam int GATE_W = N_MAC + 2;
  localparam logic [TMR_W-1:0] TMR_INIT = '1;

  logic wr_stat, wr_en, wr_cfg, wr_pmstat, wr_pmen, wr_reload;
  assign wr_stat   = reg_wr & (reg_addr == A_STAT);
  assign wr_en     = reg_wr & (reg_addr == A_EN);
  assign wr_cfg    = reg_wr & (reg_addr == A_CFG);
  assign wr_pmstat = reg_wr & (reg_addr == A_PMSTAT);
  assign wr_pmen   = reg_wr & (reg_addr == A_PMEN);
  assign wr_reload = reg_wr & (reg_addr == A_RELOAD);

  // Configuration and enable registers
  logic             master_en, tmr_run;
  logic [N_MAC-1:0] en_mac;
  logic             en_pm, en_tmr;
  logic [N_PM-1:0]  pm_en;
  logic [TMR_W-1:0] reload_q;
  logic [N_PM-1:0]  pm_en_wdata, pm_clr;

  generate
    for (genvar g = 0; g < N_PM; g++) begin : g_pm_map
      assign pm_en_wdata[g] = reg_wdata[PM_POS[g]];
      assign pm_clr[g]      = wr_pmstat & reg_wdata[PM_POS[g]];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      master_en <= 1'b0;
      tmr_run   <= 1'b0;
      en_mac    <= '0;
      en_pm     <= 1'b0;
      en_tmr    <= 1'b0;
      pm_en     <= '0;
      reload_q  <= TMR_INIT;
    end else begin
      if (wr_cfg) begin
        master_en <= reg_wdata[B_IRQ_EN];
        tmr_run   <= reg_wdata[B_TMR_RUN];
      end
      if (wr_en) begin
        en_mac <= reg_wdata[N_MAC-1:0];
        en_pm  <= reg_wdata[B_PM_SUM];
        en_tmr <= reg_wdata[B_TIMER];
      end
      if (wr_pmen)   pm_en    <= pm_en_wdata;
      if (wr_reload) reload_q <= reg_wdata[TMR_W-1:0];
    end
  end

  // Status banks
  logic [N_MAC-1:0] mac_stat;
  logic [N_PM-1:0]  pm_stat;
  logic             tmr_stat, tmr_wrap;
  logic [TMR_W-1:0] tmr_count;

  irq_w1c_bank #(.W(N_MAC)) u_mac_bank (
    .clk(clk), .rst(rst), .set_i(mac_evt),
    .clr_i(wr_stat ? reg_wdata[N_MAC-1:0] : '0),
    .stat_o(mac_stat)
  );

  irq_w1c_bank #(.W(N_PM)) u_pm_bank (
    .clk(clk), .rst(rst), .set_i(pm_evt), .clr_i(pm_clr), .stat_o(pm_stat)
  );

  irq_w1c_bank #(.W(1)) u_tmr_bank (
    .clk(clk), .rst(rst), .set_i(tmr_wrap),
    .clr_i(wr_stat & reg_wdata[B_TIMER]), .stat_o(tmr_stat)
  );

  irq_gp_timer #(.CNT_W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .run_i(tmr_run), .load_i(wr_reload),
    .load_val_i(reg_wdata[TMR_W-1:0]), .count_o(tmr_count), .wrap_o(tmr_wrap)
  );

  logic pm_sum;
  assign pm_sum = |(pm_stat & pm_en);

  irq_out_gate #(.W(GATE_W)) u_gate (
    .clk(clk), .rst(rst),
    .pend_i({mac_stat, pm_sum, tmr_stat & tmr_run}),
    .en_i({en_mac, en_pm, en_tmr}),
    .master_i(master_en), .irq_o(irq)
  );

  // Register read view
  logic [REG_DW-1:0] v_stat, v_en, v_cfg, v_pmstat, v_pmen;
  always_comb begin
    v_stat = '0; v_en = '0; v_cfg = '0; v_pmstat = '0; v_pmen = '0;
    v_stat[N_MAC-1:0] = mac_stat;
    v_stat[B_PM_SUM]  = pm_sum;
    v_stat[B_TIMER]   = tmr_stat;
    v_en[N_MAC-1:0]   = en_mac;
    v_en[B_PM_SUM]    = en_pm;
    v_en[B_TIMER]     = en_tmr;
    v_cfg[B_IRQ_EN]   = master_en;
    v_cfg[B_TMR_RUN]  = tmr_run;
    for (int k = 0; k < N_PM; k++) begin
      v_pmstat[PM_POS[k]] = pm_stat[k];
      v_pmen[PM_POS[k]]   = pm_en[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      unique case (reg_addr)
        A_STAT:   reg_rdata <= v_stat;
        A_EN:     reg_rdata <= v_en;
        A_CFG:    reg_rdata <= v_cfg;
        A_PMSTAT: reg_rdata <= v_pmstat;
        A_PMEN:   reg_rdata <= v_pmen;
        A_RELOAD: reg_rdata <= {{(REG_DW-TMR_W){1'b0}}, reload_q};
        A_COUNT:  reg_rdata <= {{(REG_DW-TMR_W){1'b0}}, tmr_count};
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int N_MAC = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [REG_DW-1:0] reg_wdata,
  input logic [N_MAC-1:0]  mac_evt,
  input logic [N_PM-1:0]   pm_evt,
  input logic [N_MAC-1:0]  mac_stat,
  input logic [N_PM-1:0]   pm_stat,
  input logic              tmr_stat,
  input logic              tmr_run,
  input logic [TMR_W-1:0]  tmr_count,
  input logic              master_en,
  input logic              irq
);
  logic reload_wr;
  assign reload_wr = reg_wr && (reg_addr == A_RELOAD);

  // R2 and R4: an event always lands in its status bit
  p_mac_latch_r2: assert property (@(posedge clk) disable iff (rst)
    (|mac_evt) |=> ((mac_stat & $past(mac_evt)) == $past(mac_evt)));

  // R5: power events land in the sub-level status
  p_pm_latch_r5: assert property (@(posedge clk) disable iff (rst)
    (|pm_evt) |=> ((pm_stat & $past(pm_evt)) == $past(pm_evt)));

  // R3: write-one clears bit 0 when no event races it
  p_w1c_bit0_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_STAT && reg_wdata[0] && !mac_evt[0]) |=> !mac_stat[0]);

  // R7: stopped timer holds its count
  p_timer_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!tmr_run && !reload_wr) |=> $stable(tmr_count));

  // R8: wrap from zero gives FFFFh and a pending timer bit
  p_timer_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (tmr_run && tmr_count == '0 && !reload_wr) |=> (tmr_count == '1 && tmr_stat));

  // R10: no request without the master enable
  p_master_gate_r10: assert property (@(posedge clk) disable iff (rst)
    !master_en |=> !irq);
endmodule

bind irq_agg_top irq_agg_chk #(.N_MAC(N_MAC)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mac_evt(mac_evt), .pm_evt(pm_evt),
  .mac_stat(mac_stat), .pm_stat(pm_stat), .tmr_stat(tmr_stat),
  .tmr_run(tmr_run), .tmr_count(tmr_count), .master_en(master_en), .irq(irq)
);

// File: tb/sim_irq_agg_top.sv
module sim_irq_agg_top;
  localparam int N_MAC = 13;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_MAC = 2'd2, OP_PM = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{OP_RD,  3'd0, 32'h0,       32'h0},        // R1 status
    '{OP_RD,  3'd6, 32'h0,       32'h0000FFFF}, // R1 count
    '{OP_RD,  3'd2, 32'h0,       32'h0},        // R1 config
    '{OP_MAC, 3'd0, 32'h5,       32'h0},
    '{OP_RD,  3'd0, 32'h0,       32'h5},        // R2 latched though disabled
    '{OP_WR,  3'd0, 32'h4,       32'h0},
    '{OP_RD,  3'd0, 32'h0,       32'h1},        // R3 clear by 1
    '{OP_WR,  3'd0, 32'h0,       32'h0},
    '{OP_RD,  3'd0, 32'h0,       32'h1},        // R3 zero no effect
    '{OP_PM,  3'd0, 32'h5,       32'h0},
    '{OP_RD,  3'd3, 32'h0,       32'h8200},     // R5 bits 15 and 9
    '{OP_RD,  3'd0, 32'h0,       32'h1},        // R6 no sub-enable, no summary
    '{OP_WR,  3'd4, 32'h0200,    32'h0},
    '{OP_RD,  3'd0, 32'h0,       32'h20001},    // R6 summary up
    '{OP_WR,  3'd0, 32'h20000,   32'h0},
    '{OP_RD,  3'd0, 32'h0,       32'h20001},    // R6 read-only
    '{OP_WR,  3'd3, 32'h0200,    32'h0},
    '{OP_RD,  3'd0, 32'h0,       32'h1},        // R6 drops, bit15 not enabled
    '{OP_RD,  3'd3, 32'h0,       32'h8000},     // R3 sub-level clear
    '{OP_WR,  3'd0, 32'h1,       32'h0},
    '{OP_RD,  3'd0, 32'h0,       32'h0}         // R3
  };

  logic clk = 1'b0, rst = 1'b1, reg_wr = 1'b0, irq;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [N_MAC-1:0] mac_evt = '0;
  logic [2:0] pm_evt = '0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  irq_agg_top #(.N_MAC(N_MAC)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mac_evt(mac_evt),
    .pm_evt(pm_evt), .irq(irq)
  );

  // All tasks enter and leave on a falling edge.
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // R11: data appears one clock after the address
  task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
    reg_addr = a;
    @(negedge clk);
    chk(req, reg_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hang expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      case (TBL[i].op)
        OP_WR: wr(TBL[i].addr, TBL[i].data);
        OP_RD: rd($sformatf("R1-6 vector %0d", i), TBL[i].addr, TBL[i].exp);
        OP_MAC: begin
          mac_evt = TBL[i].data[N_MAC-1:0]; @(negedge clk); mac_evt = '0;
        end
        default: begin
          pm_evt = TBL[i].data[2:0]; @(negedge clk); pm_evt = '0;
        end
      endcase
    end

    // R4: event and clear of bit 3 in one cycle
    mac_evt = 13'h8; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h8;
    @(negedge clk);
    mac_evt = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd("R4 set wins", 3'd0, 32'h8);

    // R10: gating and one-clock latency
    wr(3'd1, 32'h8);
    rd("R11 enable readback", 3'd1, 32'h8);
    chk("R10 master off", {31'b0, irq}, 32'h0);
    wr(3'd2, 32'h100);
    chk("R10 latency before", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R10 irq up", {31'b0, irq}, 32'h1);
    wr(3'd0, 32'h8);
    chk("R10 latency clear", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R10 irq down", {31'b0, irq}, 32'h0);

    // R9, R7: reload and stopped timer
    wr(3'd5, 32'h2);
    rd("R9 reload loads count", 3'd6, 32'h2);
    repeat (4) @(negedge clk);
    rd("R7 stopped count holds", 3'd6, 32'h2);
    rd("R7 no wrap while stopped", 3'd0, 32'h0);

    // R8: run from 2; wrap on third edge, stop on fourth
    wr(3'd1, 32'h80000);
    wr(3'd2, 32'h2000_0100);
    repeat (3) @(negedge clk);
    wr(3'd2, 32'h100);
    rd("R8 count after wrap", 3'd6, 32'h0000FFFE);
    rd("R8 timer status", 3'd0, 32'h80000);
    chk("R10 stopped timer no irq", {31'b0, irq}, 32'h0);
    wr(3'd2, 32'h2000_0100);
    @(negedge clk);
    chk("R10 running timer irq", {31'b0, irq}, 32'h1);
    wr(3'd5, 32'h1234);
    wr(3'd2, 32'h100);
    rd("R9 reload while running", 3'd6, 32'h1233);

    // R1: reset in mid-operation
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd("R1 status after reset", 3'd0, 32'h0);
    rd("R1 reload after reset", 3'd5, 32'h0000FFFF);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule